// File: doc/BRIEF.md
# Double-Buffered Timer-Based PWM Generator

This block produces a single pulse-width modulated output from an 8-bit period timer. The timer advances once every four clocks times a selectable prescale of 1, 4 or 16. Between timer increments a 2-bit sub-count runs, so the pulse width is resolved to 10 bits even though the timer itself is only 8 bits wide. The sub-count is the clock phase when the prescale is 1, and the upper two bits of the prescale counter otherwise.

Software programs the period, the upper eight duty bits, two low duty bits, the prescale, an output-enable bit and a run bit through a small write/read register bus. Duty writes are double-buffered. The active duty sits in a shadow copy that reloads only when a period ends, so a write made part-way through a cycle never truncates or stretches that cycle. A one-clock tick marks every period boundary.

Top module: `pwm_dbuf_top`

## Requirements
- R1: After reset, `pwm_pin`, `pwm_oe` and `period_tick` are low and all four bus addresses read back zero.
- R2: The register map is as follows. Address 1 holds the period value PV and address 2 holds the duty upper byte. Address 0 is the control byte: bit 0 = run, bits 2:1 = prescale select (0 gives prescale P = 1, 1 gives P = 4, 2 or 3 gives P = 16), bits 4:3 = duty low bits, bit 5 = output enable. While running, `period_tick` pulses for one clock every (PV+1)*4*P clocks.
- R3: The 10-bit active duty is D = {duty upper byte, control bits 4:3}. When 0 < D < (PV+1)*4, `pwm_pin` is high for exactly D*P clocks of each period and low for the rest.
- R4: A duty write takes effect only at the next period boundary. Until then the current period keeps the old width. Address 3 returns the upper byte of the active duty, and that value changes only when `period_tick` is high.
- R5: When D = 0, the output is never set at the boundary, so `pwm_pin` stays low for whole periods while `period_tick` still pulses.
- R6: When D >= (PV+1)*4, `pwm_pin` stays high for the whole period.
- R7: After a write that clears the run bit, `pwm_pin` is low by the second clock edge after the write edge, and no further `period_tick` occurs.
- R8: `pwm_oe` follows control bit 5. While that bit is 0, `pwm_pin` stays low even though the timer keeps running.
- R9: Writes to address 3 are ignored. The shadow readback and the output waveform are unchanged by them.
- R10: In a cycle where `period_tick` is high with D > 0 and the output enabled, `pwm_pin` is already high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pwm_pin | output | 1 | PWM output, gated by the output enable |
| pwm_oe | output | 1 | Output-enable for the pin driver |
| period_tick | output | 1 | One-clock pulse at each period boundary |

## Verification
A timer or prescale counter in the wrong state shows up directly at the ports. The gap between two `period_tick` pulses comes out wrong, and so does the count of high clocks measured against D*P, both within one period. A shadow register that loads outside the boundary shows in the address-3 readback, and on the pin at a sample taken mid-period, before the next tick. A corrupted output flop shows as a pin level that disagrees with a tick cycle or with the expected high count in that same period.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_PERIOD = 2'd1,
        REG_DUTY   = 2'd2,
        REG_SHADOW = 2'd3
    } reg_addr_e;

    // Control byte field positions
    localparam int CTRL_RUN     = 0;
    localparam int CTRL_SEL_LO  = 1;
    localparam int CTRL_SEL_HI  = 2;
    localparam int CTRL_DLO_LO  = 3;
    localparam int CTRL_DLO_HI  = 4;
    localparam int CTRL_OE      = 5;
endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
    import pwm_dbuf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SUB_W  = 2,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] shadow_hi,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              run,
    output logic [SEL_W-1:0]  ps_sel,
    output logic [SUB_W-1:0]  duty_lo,
    output logic              oe,
    output logic [DATA_W-1:0] period,
    output logic [DATA_W-1:0] duty_hi
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] period;
        logic [DATA_W-1:0] duty;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (bus_wr) begin
            case (bus_addr)
                REG_CTRL:   s_d.ctrl   = bus_wdata;
                REG_PERIOD: s_d.period = bus_wdata;
                REG_DUTY:   s_d.duty   = bus_wdata;
                default:    ;   // shadow is read-only
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (bus_addr)
            REG_CTRL:   bus_rdata = s_q.ctrl;
            REG_PERIOD: bus_rdata = s_q.period;
            REG_DUTY:   bus_rdata = s_q.duty;
            default:    bus_rdata = shadow_hi;
        endcase
    end

    assign run     = s_q.ctrl[CTRL_RUN];
    assign ps_sel  = s_q.ctrl[CTRL_SEL_HI:CTRL_SEL_LO];
    assign duty_lo = s_q.ctrl[CTRL_DLO_HI:CTRL_DLO_LO];
    assign oe      = s_q.ctrl[CTRL_OE];
    assign period  = s_q.period;
    assign duty_hi = s_q.duty;

    // R9: a write to the read-only address leaves every register untouched
    p_ro_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_SHADOW) |=> $stable(s_q));
endmodule

// File: rtl/pwm_dbuf_prescale.sv
module pwm_dbuf_prescale #(
    parameter int SUB_W    = 2,
    parameter int PRE_LOG2 = 4,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_end,
    output logic [SUB_W-1:0] sub_nx
);
    localparam int FRAC_W = SUB_W + PRE_LOG2;

    typedef struct packed {
        logic [FRAC_W-1:0] frac;
    } pre_t;

    pre_t s_d, s_q;
    int unsigned sh;
    logic [FRAC_W-1:0] lim;

    always_comb begin
        sh = 2 * int'(unsigned'(sel));
        if (sh > PRE_LOG2) sh = PRE_LOG2;
        lim = FRAC_W'((1 << (SUB_W + sh)) - 1);
        tick_end = run && (s_q.frac >= lim);
        s_d = s_q;
        if (!run)          s_d.frac = '0;
        else if (tick_end) s_d.frac = '0;
        else               s_d.frac = s_q.frac + FRAC_W'(1);
        sub_nx = SUB_W'(s_d.frac >> sh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: a stopped block holds its fraction counter at zero
    p_idle_frac_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.frac == '0));
endmodule

// File: rtl/pwm_dbuf_core.sv
module pwm_dbuf_core #(
    parameter int TMR_W = 8,
    parameter int SUB_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_end,
    input  logic [SUB_W-1:0] sub_nx,
    input  logic [TMR_W-1:0] period,
    input  logic [TMR_W-1:0] duty_hi,
    input  logic [SUB_W-1:0] duty_lo,
    output logic             pwm_out,
    output logic             tick,
    output logic [TMR_W-1:0] shadow_hi
);
    localparam int DUTY_W = TMR_W + SUB_W;

    typedef struct packed {
        logic [TMR_W-1:0] timer;
        logic [TMR_W-1:0] sh_hi;
        logic [SUB_W-1:0] sh_lo;
        logic             out;
        logic             tick;
    } core_t;

    core_t s_d, s_q;
    logic              boundary;
    logic [DUTY_W-1:0] duty_new;
    logic [DUTY_W-1:0] cnt_nx;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        boundary = 1'b0;
        duty_new = {duty_hi, duty_lo};
        cnt_nx   = {s_q.timer, sub_nx};
        if (!run) begin
            s_d.timer = '0;
            s_d.out   = 1'b0;
        end else begin
            if (tick_end) begin
                if (s_q.timer == period) begin
                    boundary  = 1'b1;
                    s_d.timer = '0;
                end else begin
                    s_d.timer = s_q.timer + TMR_W'(1);
                end
            end
            cnt_nx = {s_d.timer, sub_nx};
            if (boundary) begin
                s_d.sh_hi = duty_hi;
                s_d.sh_lo = duty_lo;
                s_d.out   = (duty_new != '0);
                s_d.tick  = 1'b1;
            end else if (cnt_nx == {s_q.sh_hi, s_q.sh_lo}) begin
                s_d.out = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm_out   = s_q.out;
    assign tick      = s_q.tick;
    assign shadow_hi = s_q.sh_hi;

    // R4: the shadow duty only changes on a period boundary
    p_shadow_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({s_q.sh_hi, s_q.sh_lo}) |-> s_q.tick);
    // R5: zero active duty never drives the output high
    p_zero_duty_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({s_q.sh_hi, s_q.sh_lo} == '0) |-> !s_q.out);
    // R7: stopping forces the output low on the next edge
    p_stop_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !s_q.out);
    // R10: a boundary with nonzero duty starts the pulse
    p_tick_sets_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.tick && ({s_q.sh_hi, s_q.sh_lo} != '0)) |-> s_q.out);
endmodule

// File: rtl/pwm_dbuf_top.sv
module pwm_dbuf_top #(
    parameter int DATA_W   = 8,
    parameter int SUB_W    = 2,
    parameter int PRE_LOG2 = 4,
    parameter int SEL_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_pin,
    output logic              pwm_oe,
    output logic              period_tick
);
    logic              run, oe, tick_end, out_raw;
    logic [SEL_W-1:0]  ps_sel;
    logic [SUB_W-1:0]  duty_lo, sub_nx;
    logic [DATA_W-1:0] period, duty_hi, shadow_hi;

    pwm_dbuf_regs #(.DATA_W(DATA_W), .SUB_W(SUB_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .shadow_hi(shadow_hi), .bus_rdata(bus_rdata),
        .run(run), .ps_sel(ps_sel), .duty_lo(duty_lo), .oe(oe),
        .period(period), .duty_hi(duty_hi)
    );

    pwm_dbuf_prescale #(.SUB_W(SUB_W), .PRE_LOG2(PRE_LOG2), .SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(ps_sel),
        .tick_end(tick_end), .sub_nx(sub_nx)
    );

    pwm_dbuf_core #(.TMR_W(DATA_W), .SUB_W(SUB_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run), .tick_end(tick_end),
        .sub_nx(sub_nx), .period(period), .duty_hi(duty_hi), .duty_lo(duty_lo),
        .pwm_out(out_raw), .tick(period_tick), .shadow_hi(shadow_hi)
    );

    assign pwm_oe  = oe;
    assign pwm_pin = out_raw & oe;
endmodule

// File: tb/sim_pwm_dbuf_top.sv
`timescale 1ns/1ps
module sim_pwm_dbuf_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       pwm_pin, pwm_oe, period_tick;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    pwm_dbuf_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_pin(pwm_pin),
        .pwm_oe(pwm_oe), .period_tick(period_tick)
    );

    always #10 clk = ~clk;

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL R2 watchdog: cycles %0d expected below %0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_ctrl(input int run, input int sel, input int lo, input int oe);
        return 8'(run | (sel << 1) | (lo << 3) | (oe << 5));
    endfunction

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic sync_tick();
        @(negedge clk);
        while (!period_tick) @(negedge clk);
    endtask

    // Counts one full period starting at a tick sample
    task automatic measure(output int per, output int hi);
        sync_tick();
        per = 0; hi = 0;
        do begin
            if (pwm_pin) hi++;
            per++;
            @(negedge clk);
        end while (!period_tick);
    endtask

    task automatic setup(input int pv, input int dhi, input int sel, input int lo, input int oe);
        wr_reg(2'd1, 8'(pv));
        wr_reg(2'd2, 8'(dhi));
        wr_reg(2'd0, mk_ctrl(1, sel, lo, oe));
    endtask

    function automatic int exp_hi(input int pv, input int d, input int p);
        if (d >= (pv + 1) * 4) return (pv + 1) * 4 * p;
        return d * p;
    endfunction

    task automatic t_reset();
        int v;
        chk("R1 pin", int'(pwm_pin), 0);
        chk("R1 oe", int'(pwm_oe), 0);
        chk("R1 tick", int'(period_tick), 0);
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), v);
            chk("R1 readback", v, 0);
        end
    endtask

    task automatic t_basic();
        int per, hi, v;
        setup(9, 3, 0, 2, 1);
        measure(per, hi);
        chk("R2 period P=1", per, 40);
        chk("R3 high P=1", hi, exp_hi(9, 14, 1));
        sync_tick();
        chk("R10 pin at tick", int'(pwm_pin), 1);
        rd_reg(2'd3, v);
        chk("R4 shadow readback", v, 3);
    endtask

    task automatic t_prescale();
        int per, hi;
        wr_reg(2'd0, mk_ctrl(1, 1, 2, 1));
        measure(per, hi);
        chk("R2 period P=4", per, 160);
        chk("R3 high P=4", hi, exp_hi(9, 14, 4));
        wr_reg(2'd0, mk_ctrl(1, 2, 2, 1));
        measure(per, hi);
        chk("R2 period P=16", per, 640);
        chk("R3 high P=16", hi, exp_hi(9, 14, 16));
        wr_reg(2'd0, mk_ctrl(1, 3, 2, 1));
        measure(per, hi);
        chk("R2 period sel3", per, 640);
        wr_reg(2'd0, mk_ctrl(1, 0, 2, 1));
    endtask

    task automatic t_buffer();
        int per, hi, v;
        sync_tick();
        wr_reg(2'd2, 8'd5);
        rd_reg(2'd3, v);
        chk("R4 shadow before boundary", v, 3);
        repeat (15) @(negedge clk);
        chk("R4 old width kept mid-period", int'(pwm_pin), 0);
        sync_tick();
        rd_reg(2'd3, v);
        chk("R4 shadow after boundary", v, 5);
        measure(per, hi);
        chk("R4 new width applied", hi, 22);
    endtask

    task automatic t_zero();
        int per, hi;
        setup(9, 0, 0, 0, 1);
        measure(per, hi);
        chk("R5 zero duty high count", hi, 0);
        chk("R5 tick still periodic", per, 40);
        wr_reg(2'd0, mk_ctrl(1, 0, 1, 1));
        measure(per, hi);
        chk("R3 duty one", hi, 1);
    endtask

    task automatic t_full();
        int per, hi;
        setup(9, 10, 0, 0, 1);
        measure(per, hi);
        chk("R6 duty over period", hi, 40);
        setup(9, 9, 0, 3, 1);
        measure(per, hi);
        chk("R3 duty one below full", hi, 39);
        setup(9, 9, 1, 3, 1);
        measure(per, hi);
        chk("R3 duty 39 P=4", hi, 156);
    endtask

    task automatic t_oe();
        int per, hi;
        setup(9, 3, 0, 2, 0);
        measure(per, hi);
        chk("R8 oe low", int'(pwm_oe), 0);
        chk("R8 pin gated", hi, 0);
        chk("R8 timer runs", per, 40);
        wr_reg(2'd0, mk_ctrl(1, 0, 2, 1));
        chk("R8 oe high", int'(pwm_oe), 1);
    endtask

    task automatic t_ro();
        int per, hi, v;
        setup(9, 3, 0, 2, 1);
        sync_tick();
        wr_reg(2'd3, 8'hAA);
        rd_reg(2'd3, v);
        chk("R9 shadow unchanged", v, 3);
        measure(per, hi);
        chk("R9 waveform unchanged", hi, 14);
        chk("R9 period unchanged", per, 40);
    endtask

    task automatic t_off();
        int ticks, v;
        setup(9, 3, 0, 2, 1);
        sync_tick();
        wr_reg(2'd0, 8'd0);
        @(negedge clk);
        chk("R7 pin low after stop", int'(pwm_pin), 0);
        ticks = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (period_tick) ticks++;
            if (pwm_pin) ticks += 1000;
        end
        chk("R7 no ticks or pulses when stopped", ticks, 0);
        rd_reg(2'd0, v);
        chk("R7 control cleared", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_prescale();
        t_buffer();
        t_zero();
        t_full();
        t_oe();
        t_ro();
        t_off();
        finish_run();
    end
endmodule